// File: doc/BRIEF.md
# Shared 4x4 Multi-Mode Integer Transform

This block computes one of four separable 4x4 integer transforms used by a high-profile video encoder or decoder: the forward core transform, the inverse core transform, the forward Hadamard transform and the inverse Hadamard transform. A two-bit mode input selects the transform for each block. The whole 4x4 block of signed samples is presented in parallel, and the 4x4 result comes back in parallel.

One array of four 4-point butterflies does all the arithmetic. The array is built so that reordering the input pairs and applying shifts turns it into any of the four matrices. It runs twice per block. The first pass works on the rows and leaves its results in a transpose register. The second pass works on the columns of that register. A new block is accepted every second cycle. Quantisation, normalisation scaling, scan ordering and the final rounding of reconstructed samples belong to neighbouring blocks.

Top module: `xform4_multi`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0, `in_ready` is 1 and `out_blk` is all zeros.
- R2: Mode 0 (forward core) returns Y = C·X·Cᵀ, where C has rows [1 1 1 1], [2 1 -1 -2], [1 -1 -1 1], [1 -2 2 -1]. Element (r,c) of a block sits at bits [(4r+c)·W +: W], where W is the element width of that port.
- R3: Mode 1 (inverse core) first transforms each row and then each column with the inverse kernel. Its half coefficients are applied as an arithmetic right shift by one of the odd inputs, which makes the result bit-exact with the usual integer inverse before rounding.
- R4: Mode 2 (forward Hadamard) returns H·X·H, where H has rows [1 1 1 1], [1 1 -1 -1], [1 -1 -1 1], [1 -1 1 -1]. Each result is then arithmetic-shifted right by one, which rounds it toward minus infinity.
- R5: Mode 3 (inverse Hadamard) returns H·X·H with no scaling.
- R6: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is then 1 for exactly one cycle, after the next rising edge.
- R7: `in_ready` is 0 for the cycle that follows an acceptance. Any `in_valid`, data or mode presented in that cycle is ignored and produces no result.
- R8: `out_blk` keeps its value in every cycle in which `out_valid` is 0.
- R9: The mode is captured when a block is accepted. Changes on `in_mode` while that block is in flight do not affect its result.
- R10: For any in-range IW-bit input, including all-maximum, all-minimum and alternating extremes, the result is exact in the IW+6-bit output elements with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block present |
| in_mode | input | 2 | Transform select: 0 fwd core, 1 inv core, 2 fwd Hadamard, 3 inv Hadamard |
| in_blk | input | 16·IW | Input block, signed elements, row-major |
| in_ready | output | 1 | Block can be accepted this cycle |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_blk | output | 16·(IW+6) | Result block, signed elements, row-major |

## Verification
The bench goes after the following corner cases:

- **Asymmetric kernels.** The forward and inverse core kernels are not symmetric. A design that swaps the row and column roles, or that mixes up the pair ordering, passes symmetric blocks but fails on random ones.
- **Truncating halving in the inverse.** The halving truncates, so the inverse core result depends on the order of the phases and on how odd negative values are shifted. A wrong shift or a wrong order shows up as an off-by-one in some elements.
- **Extreme blocks.** All-minimum and alternating-extreme blocks expose a transpose register or datapath that is too narrow: the result wraps and changes sign.
- **Inputs while busy.** New inputs and modes are thrown at the block during its busy cycle. A design that does not gate acceptance, or that re-reads the mode in the second phase, produces spurious pulses or results built from the wrong kernel.

// File: rtl/xf_pkg.sv
package xf_pkg;

  typedef enum logic [1:0] {
    XF_FWD_CORE = 2'd0,
    XF_INV_CORE = 2'd1,
    XF_FWD_HAD  = 2'd2,
    XF_INV_HAD  = 2'd3
  } xf_mode_e;

  localparam int XF_PTS  = 4;
  localparam int XF_ELEM = XF_PTS * XF_PTS;

endpackage

// File: rtl/xf_bfly.sv
module xf_bfly
  import xf_pkg::*;
#(
  parameter int W = 18
) (
  input  xf_mode_e          mode,
  input  logic [4*W-1:0]    x_flat,
  output logic [4*W-1:0]    y_flat
);

  function automatic logic signed [W-1:0] halve(input logic signed [W-1:0] v);
    return v >>> 1;
  endfunction

  function automatic logic signed [W-1:0] twice(input logic signed [W-1:0] v);
    return v <<< 1;
  endfunction

  logic signed [W-1:0] x [XF_PTS];
  logic signed [W-1:0] y [XF_PTS];

  for (genvar k = 0; k < XF_PTS; k++) begin : g_io
    assign x[k] = x_flat[k*W +: W];
    assign y_flat[k*W +: W] = y[k];
  end

  logic inv_sel, core_fwd;
  logic signed [W-1:0] ev_b, od_b, s0, d0, s1, d1;
  logic signed [W-1:0] sum_diff, odd_mix, odd_core, odd_plain;

  assign inv_sel  = (mode == XF_INV_CORE);
  assign core_fwd = (mode == XF_FWD_CORE);

  always_comb begin
    // first stage: pair selection realises the permutation per kernel
    ev_b = inv_sel ? x[2] : x[3];
    od_b = inv_sel ? x[3] : x[2];
    s0   = x[0] + ev_b;
    d0   = x[0] - ev_b;
    s1   = x[1] + (inv_sel ? halve(od_b) : od_b);
    d1   = (inv_sel ? halve(x[1]) : x[1]) - od_b;
    // second stage: shared adders, shift-scaled for the core forward kernel
    sum_diff  = s0 - s1;
    odd_mix   = (core_fwd ? twice(d0) : d0) + d1;
    odd_core  = d0 - (core_fwd ? twice(d1) : d1);
    odd_plain = d0 - d1;
    y[0] = s0 + s1;
    y[1] = odd_mix;
    y[2] = inv_sel ? odd_plain : sum_diff;
    y[3] = inv_sel ? sum_diff  : odd_core;
  end

endmodule

// File: rtl/xf_ctrl.sv
module xf_ctrl
  import xf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  xf_mode_e in_mode,
  output logic     in_ready,
  output logic     accept,
  output logic     col_phase,
  output logic     out_valid,
  output xf_mode_e mode_q
);

  logic phase_q, vld_q;

  assign in_ready  = ~phase_q;
  assign accept    = in_valid & ~phase_q;
  assign col_phase = phase_q;
  assign out_valid = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      vld_q   <= 1'b0;
      mode_q  <= XF_FWD_CORE;
    end else begin
      phase_q <= accept;
      vld_q   <= phase_q;
      if (accept) mode_q <= in_mode;
    end
  end

endmodule

// File: rtl/xf_tpose.sv
module xf_tpose
  import xf_pkg::*;
#(
  parameter int MW = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [XF_ELEM*MW-1:0] d_flat,
  output logic [XF_ELEM*MW-1:0] q_flat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_flat <= '0;
    else if (load) q_flat <= d_flat;
  end

endmodule

// File: rtl/xform4_multi.sv
module xform4_multi
  import xf_pkg::*;
#(
  parameter int IW = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_mode,
  input  logic [16*IW-1:0]         in_blk,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [16*(IW+6)-1:0]     out_blk
);

  localparam int GROW = 3;
  localparam int MW   = IW + GROW;
  localparam int OW   = MW + GROW;

  logic     acc_w, col_w;
  xf_mode_e mode_q, bf_mode;

  xf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (xf_mode_e'(in_mode)),
    .in_ready  (in_ready),
    .accept    (acc_w),
    .col_phase (col_w),
    .out_valid (out_valid),
    .mode_q    (mode_q)
  );

  assign bf_mode = col_w ? mode_q : xf_mode_e'(in_mode);

  logic [XF_ELEM*MW-1:0] tp_d, tp_q;
  logic [XF_ELEM*OW-1:0] res_d;
  logic                  half_out;

  assign half_out = (mode_q == XF_FWD_HAD);

  xf_tpose #(.MW(MW)) u_tpose (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (acc_w),
    .d_flat (tp_d),
    .q_flat (tp_q)
  );

  for (genvar i = 0; i < XF_PTS; i++) begin : g_lane
    logic [4*OW-1:0] bx, by;
    for (genvar k = 0; k < XF_PTS; k++) begin : g_el
      logic signed [IW-1:0] src_in;
      logic signed [MW-1:0] src_tp;
      logic signed [OW-1:0] yk;
      // lane i takes row i in the row phase and column i in the column phase
      assign src_in = in_blk[(i*XF_PTS+k)*IW +: IW];
      assign src_tp = tp_q[(k*XF_PTS+i)*MW +: MW];
      assign bx[k*OW +: OW] = col_w ? OW'(src_tp) : OW'(src_in);
      assign yk = by[k*OW +: OW];
      assign tp_d[(i*XF_PTS+k)*MW +: MW] = yk[MW-1:0];
      assign res_d[(k*XF_PTS+i)*OW +: OW] = half_out ? (yk >>> 1) : yk;
    end
    xf_bfly #(.W(OW)) u_bfly (
      .mode   (bf_mode),
      .x_flat (bx),
      .y_flat (by)
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_blk <= '0;
    else if (col_w) out_blk <= res_d;
  end

endmodule

// File: rtl/xform4_multi_chk.sv
module xform4_multi_chk #(
  parameter int OBW = 288
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           accept,
  input logic           col_phase,
  input logic           out_valid,
  input logic [OBW-1:0] out_blk
);

  // R6
  accept_to_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> col_phase);

  // R6
  col_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_phase |=> out_valid);

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_blk));

endmodule

bind xform4_multi xform4_multi_chk #(.OBW(16*OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .accept    (acc_w),
  .col_phase (col_w),
  .out_valid (out_valid),
  .out_blk   (out_blk)
);

// File: tb/xform4_multi_tb.sv
module xform4_multi_tb;

  localparam int IW = 12;
  localparam int OW = IW + 6;
  localparam int NCYC = 3000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [1:0]         in_mode = 2'd0;
  logic [16*IW-1:0]   in_blk = '0;
  logic               in_ready, out_valid;
  logic [16*OW-1:0]   out_blk;

  xform4_multi #(.IW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_blk(in_blk), .in_ready(in_ready), .out_valid(out_valid), .out_blk(out_blk)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // kernels in units of one half: 4 -> 2x, 2 -> x, 1 -> x/2 (arithmetic shift)
  localparam int KF[16] = '{2,2,2,2, 4,2,-2,-4, 2,-2,-2,2, 2,-4,4,-2};
  localparam int KI[16] = '{2,2,2,1, 2,1,-2,-2, 2,-1,-2,2, 2,-2,2,-1};
  localparam int KH[16] = '{2,2,2,2, 2,2,-2,-2, 2,-2,-2,2, 2,-2,2,-2};

  function automatic int kern(int mode, int j, int l);
    case (mode)
      0: return KF[j*4+l];
      1: return KI[j*4+l];
      default: return KH[j*4+l];
    endcase
  endfunction

  function automatic int term(int m, int v);
    case (m)
      4:  return 2 * v;
      2:  return v;
      1:  return v >>> 1;
      -1: return -(v >>> 1);
      -2: return -v;
      default: return -2 * v;
    endcase
  endfunction

  // reference model state
  int  m_out[16], m_res[16], m_mode_out, m_mode;
  bit  m_pend = 0, m_valid = 0, m_ext = 0, m_ext_out = 0;
  bit  cur_ext = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_valid = 0;
      for (int k = 0; k < 16; k++) m_out[k] = 0;
    end else begin
      m_valid = 0;
      if (m_pend) begin
        m_valid = 1; m_out = m_res; m_mode_out = m_mode; m_ext_out = m_ext; m_pend = 0;
      end else if (in_valid) begin
        int x[16], r[16];
        m_pend = 1; m_mode = int'(in_mode); m_ext = cur_ext;   // R9 mode captured here
        for (int k = 0; k < 16; k++) x[k] = int'($signed(in_blk[k*IW +: IW]));
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            r[i*4+j] = 0;
            for (int l = 0; l < 4; l++) r[i*4+j] += term(kern(m_mode, j, l), x[i*4+l]);
          end
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            m_res[i*4+j] = 0;
            for (int l = 0; l < 4; l++) m_res[i*4+j] += term(kern(m_mode, i, l), r[l*4+j]);
            if (m_mode == 2) m_res[i*4+j] = m_res[i*4+j] >>> 1;
          end
      end
    end
  end

  function automatic string mode_tag(int mode);
    case (mode)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid == m_valid, "R6 out_valid", int'(out_valid), int'(m_valid));
      check(in_ready == !m_pend, "R7 in_ready", int'(in_ready), int'(!m_pend));
      for (int k = 0; k < 16; k++) begin
        int a;
        a = int'($signed(out_blk[k*OW +: OW]));
        if (a != m_out[k]) begin
          if (!out_valid) check(0, "R8 held out_blk", a, m_out[k]);
          else if (m_ext_out) check(0, "R10 extreme block", a, m_out[k]);
          else check(0, mode_tag(m_mode_out), a, m_out[k]);
        end
      end
      if (out_valid) check(1, mode_tag(m_mode_out), 0, 0);
    end
  end

  task automatic fill(int pat);
    int mx, mn;
    mx = (1 << (IW-1)) - 1;
    mn = -(1 << (IW-1));
    cur_ext = (pat < 4);
    for (int k = 0; k < 16; k++) begin
      int v;
      case (pat)
        0: v = mx;
        1: v = mn;
        2: v = (((k >> 2) + k) % 2 == 0) ? mx : mn;
        3: v = (((k >> 2) + k) % 2 == 0) ? mn : mx;
        default: v = int'($urandom_range(0, (1 << IW) - 1)) - (1 << (IW-1));
      endcase
      in_blk[k*IW +: IW] = IW'(v);
    end
  endtask

  initial begin : watchdog
    repeat (NCYC + 500) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_blk == '0, "R1 out_blk", int'(out_blk[31:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1 && out_blk == '0, "R1 after reset",
          int'(out_valid), 0);
    // directed extremes per mode (R10), then random traffic with busy-cycle noise (R7, R9)
    for (int md = 0; md < 4; md++)
      for (int p = 0; p < 4; p++) begin
        in_valid = 1'b1; in_mode = 2'(md); fill(p);
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'($urandom_range(0, 3)); fill(5);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
      end
    for (int c = 0; c < NCYC - 100; c++) begin
      in_valid = ($urandom_range(0, 3) != 0);
      in_mode  = 2'($urandom_range(0, 3));
      fill(($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 3)) : 5);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule